// File: doc/BRIEF.md
# Port Change-Detect Interrupt Controller

This block produces the interrupt request of a two-port I/O expander with eight pins per port. Each pin level is brought into the clock domain through a short synchronizer. The synchronized level is then compared with a reference value held separately for each port. Only pins whose direction bit selects input take part in the comparison. The interrupt is a level condition, not a sticky flag. It is active whenever any input pin differs from its port's reference. It goes away by itself when the pins return to their reference levels.

The serial bus engine tells the block when the acknowledge clock edge of a port read has arrived, using one strobe per port. On that strobe the reference of that port reloads from the current synchronized pin levels. That port's share of the interrupt is dropped in the same edge, and the other port is left alone. The reference values are returned so that the bus engine can serialize them as the read data. The interrupt output is a pull-low enable for an open-drain line that idles high through an external resistor.

Top module: `chg_intr_ctrl`

## Requirements
- R1: While reset is held, each port reference follows the synchronized pin levels. After reset is released, `irq_pull_low` is 0 and `ref_val` equals the pin levels that were applied during reset.
- R2: A rising or falling change on an input pin (direction bit 1) sets `irq_pull_low` to 1 on the third rising clock edge after the change: two synchronizer stages plus one output register.
- R3: A pin whose direction bit is 0 (output) never asserts `irq_pull_low`, whatever its level.
- R4: When every changed input pin returns to the level held in its port reference, `irq_pull_low` returns to 0 with the same latency as R2, without any read.
- R5: At a rising edge where `rd_ack[p]` is 1, the reference of port p loads the synchronized pin levels, and that port stops contributing to `irq_pull_low` from the same edge.
- R6: An acknowledge on one port leaves the other port's reference and pending change untouched, so `irq_pull_low` stays 1 when the other port still differs.
- R7: With no acknowledge strobe, which is the case for all bus traffic addressed elsewhere, a pending interrupt and both references hold indefinitely.
- R8: Changing a direction bit from 0 to 1 while that pin differs from its reference asserts `irq_pull_low` at the next rising edge.
- R9: After a port has been cleared by an acknowledge, a later change on any of its input pins asserts `irq_pull_low` again.
- R10: Port p occupies bits [8p+7:8p] of `pins_async`, `dir_in` and `ref_val`. Bit p of `rd_ack` belongs to port p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pins_async | input | 16 | Raw pin levels, port p in bits [8p+7:8p] |
| dir_in | input | 16 | Direction per pin, 1 = input, 0 = output |
| rd_ack | input | 2 | One-cycle strobe per port, marks the acknowledge edge of a read of that port |
| ref_val | output | 16 | Per-port reference values, used as read data |
| irq_pull_low | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
The hardest situations to reach are those where the reference has gone stale relative to the pins. One is a pin that toggled while it was an output and is then switched back to input. The other is a read of one port while the other port still holds a change. The stimulus table creates them on purpose. It changes levels on output-mode pins, flips their direction afterwards, and places single-port acknowledges while both ports differ, checking the interrupt and both references after every step. Directed steps then measure the exact latency from a pin change to the interrupt and hold a pending change for many cycles without any strobe.

// File: rtl/chg_intr_pkg.sv
// Package: shared constants of the port change-detect interrupt block.
// Assumes: included first in compile order.
package chg_intr_pkg;
    // Direction encoding of one configuration bit.
    typedef enum logic {
        PIN_OUT = 1'b0,
        PIN_IN  = 1'b1
    } pin_dir_e;

    // Fewest synchronizer stages accepted; smaller requests are raised to this.
    localparam int unsigned SYNC_MIN_STAGES = 2;
endpackage

// File: rtl/chg_intr_sync.sv
// Module: multi-stage level synchronizer for a bus of independent pin levels.
// Assumes: each bit is an unrelated slow level, so per-bit resolution is acceptable.
// The data flops carry no reset; the chain is flushed while the top holds reset.
module chg_intr_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    import chg_intr_pkg::*;

    localparam int unsigned DEPTH = (STAGES < SYNC_MIN_STAGES) ? SYNC_MIN_STAGES : STAGES;

    logic [W-1:0] stage_q [DEPTH];

    // First stage: sample the asynchronous levels.
    always_ff @(posedge clk) begin
        stage_q[0] <= d_async;
    end

    genvar s;
    generate
        for (s = 1; s < DEPTH; s++) begin : g_stage
            // Later stages: shift the sampled levels along the chain.
            always_ff @(posedge clk) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q_sync = stage_q[DEPTH-1];
endmodule

// File: rtl/chg_intr_port.sv
// Module: reference register and change comparison for one port.
// Assumes: pins_s is already synchronized; rd_ack is a one-cycle strobe at the
// acknowledge edge of a read of this port. The reference follows the pins during reset.
module chg_intr_port #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  logic [W-1:0] dir,
    input  logic         rd_ack,
    output logic [W-1:0] ref_q,
    output logic         hit
);
    logic [W-1:0] diff;

    // Reference: track pins during reset, reload at a read acknowledge, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || rd_ack) begin
            ref_q <= pins_s;
        end
    end

    // Mismatch on input-mode pins only (direction bit 1 = input).
    always_comb begin
        diff = (pins_s ^ ref_q) & dir;
        hit  = |diff;
    end

    // R5: an acknowledge captures the pin levels seen in that cycle.
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> (ref_q == $past(pins_s)));

    // R7: with no acknowledge the reference is left untouched.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ack |=> $stable(ref_q));
endmodule

// File: rtl/chg_intr_merge.sv
// Module: combines per-port mismatch flags into the registered pull-low enable.
// Assumes: port_hit reflects the reference before any reload happening this edge;
// a port being acknowledged this edge is excluded so it clears in the same edge.
module chg_intr_merge #(
    parameter int unsigned NP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] port_hit,
    input  logic [NP-1:0] rd_ack,
    output logic          irq_q
);
    logic irq_next;

    // Next state: any port still differing and not being acknowledged now.
    always_comb begin
        irq_next = |(port_hit & ~rd_ack);
    end

    // Output register: released (0) in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_next;
        end
    end

    // R2: an unacknowledged mismatch drives the line low one edge later.
    assert_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(port_hit & ~rd_ack)) |=> irq_q);

    // R4: with no mismatch on any port the line is released one edge later.
    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_hit == '0) |=> !irq_q);
endmodule

// File: rtl/chg_intr_ctrl.sv
// Module: top of the port change-detect interrupt controller.
// Synchronizes pin levels, compares each port against its reference and
// drives an open-drain pull-low enable. Assumes reset is held for at least
// SYNC_STAGES+1 cycles with stable pins so the references start equal.
module chg_intr_ctrl #(
    parameter int unsigned NUM_PORTS   = 2,
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0]   pins_async,
    input  logic [NUM_PORTS*PORT_W-1:0]   dir_in,
    input  logic [NUM_PORTS-1:0]          rd_ack,
    output logic [NUM_PORTS*PORT_W-1:0]   ref_val,
    output logic                          irq_pull_low
);
    localparam int unsigned PIN_W = NUM_PORTS * PORT_W;

    logic [PIN_W-1:0]     pins_s;
    logic [NUM_PORTS-1:0] port_hit;

    chg_intr_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .d_async (pins_async),
        .q_sync  (pins_s)
    );

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_port
            chg_intr_port #(
                .W (PORT_W)
            ) u_port (
                .clk    (clk),
                .rst_n  (rst_n),
                .pins_s (pins_s[p*PORT_W +: PORT_W]),
                .dir    (dir_in[p*PORT_W +: PORT_W]),
                .rd_ack (rd_ack[p]),
                .ref_q  (ref_val[p*PORT_W +: PORT_W]),
                .hit    (port_hit[p])
            );
        end
    endgenerate

    chg_intr_merge #(
        .NP (NUM_PORTS)
    ) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_hit (port_hit),
        .rd_ack   (rd_ack),
        .irq_q    (irq_pull_low)
    );

    // R5: acknowledging every port at once always releases the line.
    assert_all_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&rd_ack) |=> !irq_pull_low);
endmodule

// File: tb/test_chg_intr_ctrl.sv
module test_chg_intr_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins_async = 16'h3CA5;
    logic [15:0] dir_in = 16'hFFFF;
    logic [1:0]  rd_ack = 2'b00;
    logic [15:0] ref_val;
    logic        irq_pull_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_intr_ctrl i_chg_intr_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pins_async   (pins_async),
        .dir_in       (dir_in),
        .rd_ack       (rd_ack),
        .ref_val      (ref_val),
        .irq_pull_low (irq_pull_low)
    );

    typedef struct packed {
        logic [15:0] pins;
        logic [15:0] dir;
        logic [1:0]  ack;
        logic        irq;
        logic [15:0] refv;
        logic [3:0]  req;
    } vec_t;

    // Port 0 = bits [7:0], port 1 = bits [15:8] (R10); dir 1 = input.
    localparam vec_t VEC [14] = '{
        '{16'h3CA5, 16'hFFFF, 2'b00, 1'b0, 16'h3CA5, 4'd1},  // R1 quiet after reset
        '{16'h3CA4, 16'hFFFF, 2'b00, 1'b1, 16'h3CA5, 4'd2},  // R2 falling edge port 0
        '{16'h3CA5, 16'hFFFF, 2'b00, 1'b0, 16'h3CA5, 4'd4},  // R4 return without read
        '{16'h3DA5, 16'hFFFF, 2'b00, 1'b1, 16'h3CA5, 4'd2},  // R2 rising edge port 1
        '{16'h3DA5, 16'hFFFF, 2'b01, 1'b1, 16'h3CA5, 4'd6},  // R6 read port 0 keeps port 1
        '{16'h3DA5, 16'hFFFF, 2'b10, 1'b0, 16'h3DA5, 4'd5},  // R5 read port 1 clears
        '{16'h3D5A, 16'hFF00, 2'b00, 1'b0, 16'h3DA5, 4'd3},  // R3 output pins toggle
        '{16'h3D5A, 16'hFFFF, 2'b00, 1'b1, 16'h3DA5, 4'd8},  // R8 output->input mismatch
        '{16'h3D5A, 16'hFFFF, 2'b01, 1'b0, 16'h3D5A, 4'd5},  // R5 read port 0 reloads
        '{16'h3D5B, 16'hFFFF, 2'b00, 1'b1, 16'h3D5A, 4'd9},  // R9 new change after clear
        '{16'h7D5B, 16'hFFFF, 2'b01, 1'b1, 16'h3D5B, 4'd6},  // R6 port 1 still pending
        '{16'h7D5B, 16'hFFFF, 2'b10, 1'b0, 16'h7D5B, 4'd5},  // R5 port 1 read
        '{16'h005B, 16'h00FF, 2'b00, 1'b0, 16'h7D5B, 4'd3},  // R3 port 1 as output
        '{16'h005B, 16'hFFFF, 2'b11, 1'b0, 16'h005B, 4'd5}   // R5 both ports read
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset with stable pins
        repeat (5) @(negedge clk);
        chk("R1 irq during reset", {15'd0, irq_pull_low}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", {15'd0, irq_pull_low}, 16'h0000);
        chk("R1 ref after reset", ref_val, 16'h3CA5);

        // Table walk
        foreach (VEC[i]) begin
            pins_async = VEC[i].pins;
            dir_in     = VEC[i].dir;
            rd_ack     = 2'b00;
            step_edges(3);
            if (VEC[i].ack != 2'b00) begin
                rd_ack = VEC[i].ack;
                step_edges(1);
                rd_ack = 2'b00;
            end
            chk($sformatf("R%0d vec%0d irq", VEC[i].req, i), {15'd0, irq_pull_low}, {15'd0, VEC[i].irq});
            chk($sformatf("R%0d vec%0d ref", VEC[i].req, i), ref_val, VEC[i].refv);
        end

        // R2: exact latency, not yet after two edges, set after the third
        pins_async = 16'h005A;
        step_edges(2);
        chk("R2 not before third edge", {15'd0, irq_pull_low}, 16'h0000);
        step_edges(1);
        chk("R2 set at third edge", {15'd0, irq_pull_low}, 16'h0001);

        // R7: no strobe for a long stretch, state must hold
        step_edges(60);
        chk("R7 irq held", {15'd0, irq_pull_low}, 16'h0001);
        chk("R7 ref held", ref_val, 16'h005B);

        // R4: return to reference releases with same latency
        pins_async = 16'h005B;
        step_edges(3);
        chk("R4 release", {15'd0, irq_pull_low}, 16'h0000);

        // R1: second reset with different pins reloads references
        pins_async = 16'h1234;
        rst_n = 1'b0;
        step_edges(5);
        rst_n = 1'b1;
        step_edges(1);
        chk("R1 irq after re-reset", {15'd0, irq_pull_low}, 16'h0000);
        chk("R1 ref after re-reset", ref_val, 16'h1234);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule